// File: doc/BRIEF.md
# Interrupt and Error Code Controller

This block collects interrupt sources for a keypad companion device and drives one active-low interrupt request line towards a host processor. The sources are:

- a one-cycle pulse for each new key event;
- one-cycle error pulses from the keypad and command logic;
- an edge on either of two general-purpose pins, when that pin has its external interrupt enabled and is configured as an input.

The block holds three registers that the host reads: an interrupt code, an error code and a status byte. The interrupt code and the error code are cleared when they are read. The status byte reports the result of the last host command or a wake caused by a pin edge.

The host interface decodes register reads and gives the block a one-cycle read strobe for each code register. The block samples the strobe on the same clock edge as any new event. Events that arrive in the cycle of a clearing read land in the register after the clear, so they are kept. Each enabled pin edge also produces a one-cycle wake pulse, which a power controller can use to leave standby.

Top module: `irq_code_ctrl`

## Requirements
- R1: After synchronous reset the outputs are idle: `irq_n_o` is 1, `int_code_o` is 0x00, `err_code_o` is 0x00, `status_o` is 0x00 and `wake_o` is 0.
- R2: A pulse on `key_evt_i` sets interrupt code bit 0 at the next clock edge, and `irq_n_o` goes low in the same cycle. `irq_n_o` is low whenever the interrupt code is non-zero.
- R3: When `xint_en_i` is 2'b11, an edge on pin 0 sets only interrupt code bit 1, and an edge on pin 1 sets only bit 2.
- R4: When exactly one bit of `xint_en_i` is set (bit 0 enables pin 0, bit 1 enables pin 1), an edge on the enabled pin sets both bit 1 and bit 2 (code 0x06).
- R5: Both a rising and a falling pin edge count. The pin passes through a two-flop synchronizer, so the code updates on the third clock edge after the pin changes. An edge has no effect when the pin's enable bit is 0 or when its `gpio_dir_i` bit is 1 (output).
- R6: A pulse on `rd_int_i` clears the interrupt code and releases `irq_n_o` at the next edge. Events that arrive in the same cycle are set after the clear.
- R7: Error pulses set error code bits as follows: command overrun sets bit 0, unknown command sets bit 1, key overrun sets bit 2, FIFO overrun sets bit 6. Any error also sets interrupt code bit 3. Error code bits 3, 5 and 7 and interrupt code bits 7:4 are always 0.
- R8: A pulse on `rd_err_i` clears the error code. Error pulses in the same cycle are set after the clear.
- R9: An enabled edge is lost if it arrives while its source is still pending in the interrupt code and no interrupt read occurs in that cycle. A source is pending when its own bit is set (both pins enabled), or when bit 1 or bit 2 is set (one pin enabled). A lost edge sets error code bit 4 and interrupt code bit 3.
- R10: The status byte becomes 0x06 after `cmd_done_i` with `cmd_ok_i`=1, 0x15 after `cmd_done_i` with `cmd_ok_i`=0, and 0x02 after an enabled pin edge. A command result takes priority over a pin edge in the same cycle.
- R11: `wake_o` pulses high for exactly one cycle, in the cycle where an enabled pin edge enters the interrupt code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_evt_i | input | 1 | One-cycle pulse: a new key event is stored |
| err_fifo_ovr_i | input | 1 | One-cycle pulse: key event dropped because the FIFO was full |
| err_key_ovr_i | input | 1 | One-cycle pulse: too many keys pressed at once |
| err_cmd_ovr_i | input | 1 | One-cycle pulse: command arrived before it could be taken |
| err_cmd_unk_i | input | 1 | One-cycle pulse: unknown command code |
| gpio_pin_i | input | 2 | Raw levels of the two interrupt-capable pins |
| xint_en_i | input | 2 | External interrupt enable: bit 0 is pin 0, bit 1 is pin 1 |
| gpio_dir_i | input | 2 | Pin direction: 1 is output, 0 is input |
| cmd_done_i | input | 1 | One-cycle pulse: a host command has finished |
| cmd_ok_i | input | 1 | Result of the finished command, valid with `cmd_done_i` |
| rd_int_i | input | 1 | One-cycle read strobe for the interrupt code |
| rd_err_i | input | 1 | One-cycle read strobe for the error code |
| irq_n_o | output | 1 | Active-low interrupt request |
| int_code_o | output | 8 | Interrupt code register |
| err_code_o | output | 8 | Error code register |
| status_o | output | 8 | Status byte |
| wake_o | output | 1 | One-cycle wake pulse on an enabled pin edge |

## Verification
The assertions assume the following about the inputs:

- The event, error, command-done and read inputs are single-cycle pulses, sampled on the clock edge.
- `cmd_ok_i` is meaningful only with `cmd_done_i`.
- The pin levels are low while reset is held, so the synchronizer does not see a false edge when reset is released.

The stimulus drives every input at the falling clock edge and holds the pins at zero through reset. It changes a pin only after the previous edge has fully passed through the synchronizer. It raises a read strobe only for one cycle at a time, except where it deliberately makes an event coincide with a clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int CODE_W  = 8;
    localparam int NUM_XIN = 2;

    // interrupt code bit positions (decoded by host software)
    localparam int INT_KEY = 0;
    localparam int INT_X0  = 1;
    localparam int INT_X1  = 2;
    localparam int INT_ERR = 3;

    // error code bit positions
    localparam int ERR_CMD_OVR  = 0;
    localparam int ERR_CMD_UNK  = 1;
    localparam int ERR_KEY_OVR  = 2;
    localparam int ERR_LOST     = 4;
    localparam int ERR_FIFO_OVR = 6;

    typedef enum logic [CODE_W-1:0] {
        ST_RESET = 8'h00,
        ST_WAKE  = 8'h02,
        ST_OK    = 8'h06,
        ST_FAIL  = 8'h15
    } stat_e;

    typedef struct packed {
        logic fifo_ovr;
        logic key_ovr;
        logic cmd_unk;
        logic cmd_ovr;
    } err_evt_t;

    // Map qualified pin edges onto interrupt code bits [2:1].
    // Both enabled: one bit per source. One enabled: both bits together.
    function automatic logic [NUM_XIN-1:0] map_xint(
        input logic [NUM_XIN-1:0] en,
        input logic [NUM_XIN-1:0] hit
    );
        if (en == {NUM_XIN{1'b1}})
            return hit;
        else if (|hit)
            return {NUM_XIN{1'b1}};
        else
            return '0;
    endfunction

    function automatic logic [CODE_W-1:0] err_to_bits(input err_evt_t ev, input logic lost);
        logic [CODE_W-1:0] b;
        b               = '0;
        b[ERR_CMD_OVR]  = ev.cmd_ovr;
        b[ERR_CMD_UNK]  = ev.cmd_unk;
        b[ERR_KEY_OVR]  = ev.key_ovr;
        b[ERR_LOST]     = lost;
        b[ERR_FIFO_OVR] = ev.fifo_ovr;
        return b;
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic arm_i,
    output logic edge_o
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[CHAIN-2:0], pin_i};
    end

    // sh[SYNC_STAGES-1] is the synchronized level, sh[SYNC_STAGES] its previous value
    assign edge_o = arm_i & (sh[SYNC_STAGES-1] ^ sh[SYNC_STAGES]);

endmodule

// File: rtl/irq_int_reg.sv
module irq_int_reg
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                key_evt_i,
    input  logic                err_any_i,
    input  logic [NUM_XIN-1:0]  xbits_i,
    input  logic                rd_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                irq_n_o
);
    logic [CODE_W-1:0] code_q, code_nxt;
    logic              req_q;

    always_comb begin
        code_nxt                       = rd_i ? '0 : code_q;
        code_nxt[INT_KEY]              = code_nxt[INT_KEY] | key_evt_i;
        code_nxt[INT_X1:INT_X0]        = code_nxt[INT_X1:INT_X0] | xbits_i;
        code_nxt[INT_ERR]              = code_nxt[INT_ERR] | err_any_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            req_q  <= 1'b0;
        end else begin
            code_q <= code_nxt;
            req_q  <= |code_nxt;
        end
    end

    assign code_o  = code_q;
    assign irq_n_o = ~req_q;

endmodule

// File: rtl/irq_err_reg.sv
module irq_err_reg
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  err_evt_t          evt_i,
    input  logic              lost_i,
    input  logic              rd_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] set_bits;

    assign set_bits = err_to_bits(evt_i, lost_i);
    assign any_o    = |set_bits;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else
            code_q <= (rd_i ? '0 : code_q) | set_bits;
    end

    assign code_o = code_q;

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic              ok_i,
    input  logic              wake_evt_i,
    output logic [CODE_W-1:0] status_o
);
    stat_e st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_RESET;
        else if (done_i)
            st_q <= ok_i ? ST_OK : ST_FAIL;
        else if (wake_evt_i)
            st_q <= ST_WAKE;
    end

    assign status_o = st_q;

endmodule

// File: rtl/irq_code_ctrl.sv
module irq_code_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               key_evt_i,
    input  logic               err_fifo_ovr_i,
    input  logic               err_key_ovr_i,
    input  logic               err_cmd_ovr_i,
    input  logic               err_cmd_unk_i,
    input  logic [NUM_XIN-1:0] gpio_pin_i,
    input  logic [NUM_XIN-1:0] xint_en_i,
    input  logic [NUM_XIN-1:0] gpio_dir_i,
    input  logic               cmd_done_i,
    input  logic               cmd_ok_i,
    input  logic               rd_int_i,
    input  logic               rd_err_i,
    output logic               irq_n_o,
    output logic [CODE_W-1:0]  int_code_o,
    output logic [CODE_W-1:0]  err_code_o,
    output logic [CODE_W-1:0]  status_o,
    output logic               wake_o
);
    logic [NUM_XIN-1:0] qedge;
    logic [NUM_XIN-1:0] xbits;
    logic [NUM_XIN-1:0] pend;
    logic               lost;
    logic               err_any;
    logic               wake_q;
    err_evt_t           evt;

    for (genvar i = 0; i < NUM_XIN; i++) begin : g_xin
        irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (gpio_pin_i[i]),
            .arm_i  (xint_en_i[i] & ~gpio_dir_i[i]),
            .edge_o (qedge[i])
        );
    end

    assign xbits = map_xint(xint_en_i, qedge);

    always_comb begin
        for (int i = 0; i < NUM_XIN; i++) begin
            if (xint_en_i == {NUM_XIN{1'b1}})
                pend[i] = int_code_o[INT_X0 + i];
            else
                pend[i] = int_code_o[INT_X0] | int_code_o[INT_X1];
        end
    end

    assign lost = (|(qedge & pend)) & ~rd_int_i;

    assign evt = '{fifo_ovr: err_fifo_ovr_i,
                   key_ovr:  err_key_ovr_i,
                   cmd_unk:  err_cmd_unk_i,
                   cmd_ovr:  err_cmd_ovr_i};

    irq_err_reg u_err (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .lost_i (lost),
        .rd_i   (rd_err_i),
        .code_o (err_code_o),
        .any_o  (err_any)
    );

    irq_int_reg u_int (
        .clk       (clk),
        .rst       (rst),
        .key_evt_i (key_evt_i),
        .err_any_i (err_any),
        .xbits_i   (xbits),
        .rd_i      (rd_int_i),
        .code_o    (int_code_o),
        .irq_n_o   (irq_n_o)
    );

    irq_status_reg u_stat (
        .clk        (clk),
        .rst        (rst),
        .done_i     (cmd_done_i),
        .ok_i       (cmd_ok_i),
        .wake_evt_i (|qedge),
        .status_o   (status_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            wake_q <= 1'b0;
        else
            wake_q <= |qedge;
    end

    assign wake_o = wake_q;

endmodule

// File: rtl/irq_code_ctrl_chk.sv
module irq_code_ctrl_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               key_evt_i,
    input logic               err_fifo_ovr_i,
    input logic               err_key_ovr_i,
    input logic               err_cmd_ovr_i,
    input logic               err_cmd_unk_i,
    input logic [NUM_XIN-1:0] gpio_pin_i,
    input logic [NUM_XIN-1:0] xint_en_i,
    input logic [NUM_XIN-1:0] gpio_dir_i,
    input logic               cmd_done_i,
    input logic               cmd_ok_i,
    input logic               rd_int_i,
    input logic               rd_err_i,
    input logic               irq_n_o,
    input logic [CODE_W-1:0]  int_code_o,
    input logic [CODE_W-1:0]  err_code_o,
    input logic [CODE_W-1:0]  status_o,
    input logic               wake_o
);
    logic any_err_in;
    assign any_err_in = err_fifo_ovr_i | err_key_ovr_i | err_cmd_ovr_i | err_cmd_unk_i;

    AST_KEY_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        key_evt_i |=> (!irq_n_o && int_code_o[INT_KEY])); // R2

    AST_CODE_HOLDS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (int_code_o != '0) |-> !irq_n_o); // R2

    AST_INT_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_int_i && !key_evt_i && !any_err_in) |=> (!int_code_o[INT_KEY] && !int_code_o[INT_ERR])); // R6

    AST_UNK_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        err_cmd_unk_i |=> (err_code_o[ERR_CMD_UNK] && int_code_o[INT_ERR])); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int_code_o[7:4] == 4'h0) && !err_code_o[3] && !err_code_o[5] && !err_code_o[7]); // R7

    AST_ERR_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_err_i && !any_err_in) |=> (!err_code_o[ERR_CMD_OVR] && !err_code_o[ERR_CMD_UNK]
                                       && !err_code_o[ERR_KEY_OVR] && !err_code_o[ERR_FIFO_OVR])); // R8

    AST_STATUS_OK: assert property (@(posedge clk) disable iff (rst)
        (cmd_done_i && cmd_ok_i) |=> (status_o == 8'h06)); // R10

    AST_STATUS_FAIL: assert property (@(posedge clk) disable iff (rst)
        (cmd_done_i && !cmd_ok_i) |=> (status_o == 8'h15)); // R10

    AST_WAKE_WITH_CODE: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (int_code_o[INT_X1:INT_X0] != 2'b00)); // R11

endmodule

bind irq_code_ctrl irq_code_ctrl_chk u_chk (.*);

// File: tb/irq_code_ctrl_tb.sv
module irq_code_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_evt_i = 0, err_fifo_ovr_i = 0, err_key_ovr_i = 0;
    logic       err_cmd_ovr_i = 0, err_cmd_unk_i = 0;
    logic [1:0] gpio_pin_i = 0, xint_en_i = 0, gpio_dir_i = 0;
    logic       cmd_done_i = 0, cmd_ok_i = 0, rd_int_i = 0, rd_err_i = 0;
    logic       irq_n_o, wake_o;
    logic [7:0] int_code_o, err_code_o, status_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_code_ctrl u_dut (.*);

    // stimulus {key,fifo,keyovr,cmdovr,cmdunk,done,ok,rdint,rderr}, then int, err, status
    localparam int NV = 10;
    localparam logic [32:0] VEC [NV] = '{
        {9'b1_0000_00_00, 8'h01, 8'h00, 8'h00},
        {9'b0_0000_00_10, 8'h00, 8'h00, 8'h00},
        {9'b0_0010_00_00, 8'h08, 8'h01, 8'h00},
        {9'b0_0001_00_01, 8'h08, 8'h02, 8'h00},
        {9'b0_0100_00_00, 8'h08, 8'h06, 8'h00},
        {9'b0_1000_00_01, 8'h08, 8'h40, 8'h00},
        {9'b0_0000_11_00, 8'h08, 8'h40, 8'h06},
        {9'b0_0000_10_00, 8'h08, 8'h40, 8'h15},
        {9'b1_0000_00_11, 8'h01, 8'h00, 8'h15},
        {9'b0_0000_00_10, 8'h00, 8'h00, 8'h15}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pin_move(input int idx, input logic val);
        gpio_pin_i[idx] = val;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_int();
        rd_int_i = 1;
        @(negedge clk);
        rd_int_i = 0;
    endtask

    task automatic read_err();
        rd_err_i = 1;
        @(negedge clk);
        rd_err_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq_n", {7'd0, irq_n_o}, 8'h01);
        chk("R1 int", int_code_o, 8'h00);
        chk("R1 err", err_code_o, 8'h00);
        chk("R1 stat", status_o, 8'h00);
        chk("R1 wake", {7'd0, wake_o}, 8'h00);
        rst = 0;
        @(negedge clk);

        // table: R2 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            {key_evt_i, err_fifo_ovr_i, err_key_ovr_i, err_cmd_ovr_i, err_cmd_unk_i,
             cmd_done_i, cmd_ok_i, rd_int_i, rd_err_i} = VEC[v][32:24];
            @(negedge clk);
            {key_evt_i, err_fifo_ovr_i, err_key_ovr_i, err_cmd_ovr_i, err_cmd_unk_i,
             cmd_done_i, cmd_ok_i, rd_int_i, rd_err_i} = '0;
            chk($sformatf("R2/R6/R7 vec%0d int", v), int_code_o, VEC[v][23:16]);
            chk($sformatf("R7/R8 vec%0d err", v), err_code_o, VEC[v][15:8]);
            chk($sformatf("R10 vec%0d stat", v), status_o, VEC[v][7:0]);
            chk($sformatf("R2 vec%0d irq_n", v), {7'd0, irq_n_o}, {7'd0, VEC[v][23:16] == 8'h00});
        end

        // R3 both enabled, pin 0 rising
        xint_en_i = 2'b11; gpio_dir_i = 2'b00;
        pin_move(0, 1'b1);
        chk("R3 pin0 rise int", int_code_o, 8'h02);
        chk("R11 wake high", {7'd0, wake_o}, 8'h01);
        chk("R10 wake status", status_o, 8'h02);
        @(negedge clk);
        chk("R11 wake one cycle", {7'd0, wake_o}, 8'h00);
        read_int();
        chk("R6 cleared", int_code_o, 8'h00);
        chk("R6 irq released", {7'd0, irq_n_o}, 8'h01);

        // R3 pin 1, then R9 lost edge on falling edge while pending
        pin_move(1, 1'b1);
        chk("R3 pin1 rise int", int_code_o, 8'h04);
        pin_move(1, 1'b0);
        chk("R9 lost int", int_code_o, 8'h0C);
        chk("R9 lost err", err_code_o, 8'h10);
        read_int(); read_err();
        chk("R8 err cleared", err_code_o, 8'h00);

        // R5 falling edge counts
        pin_move(0, 1'b0);
        chk("R5 falling edge", int_code_o, 8'h02);
        read_int();

        // R4 single enable
        xint_en_i = 2'b01;
        pin_move(0, 1'b1);
        chk("R4 only pin0 enabled", int_code_o, 8'h06);
        read_int();
        xint_en_i = 2'b10;
        pin_move(1, 1'b1);
        chk("R4 only pin1 enabled", int_code_o, 8'h06);
        read_int();

        // R5 ignored when disabled
        xint_en_i = 2'b00;
        pin_move(0, 1'b0);
        @(negedge clk);
        chk("R5 disabled int", int_code_o, 8'h00);
        chk("R5 disabled irq", {7'd0, irq_n_o}, 8'h01);
        chk("R11 disabled wake", {7'd0, wake_o}, 8'h00);

        // R5 ignored when pin is output
        xint_en_i = 2'b11; gpio_dir_i = 2'b01;
        pin_move(0, 1'b1);
        @(negedge clk);
        chk("R5 output pin int", int_code_o, 8'h00);
        gpio_dir_i = 2'b10;
        pin_move(0, 1'b0);
        chk("R5 input pin still works", int_code_o, 8'h02);

        // R10 command result beats pin edge in the same cycle
        gpio_pin_i[0] = 1'b1;
        repeat (2) @(negedge clk);
        cmd_done_i = 1; cmd_ok_i = 1;
        @(negedge clk);
        cmd_done_i = 0; cmd_ok_i = 0;
        chk("R10 priority", status_o, 8'h06);
        read_int();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule